// File: doc/BRIEF.md
# Register Operand Bypass Controller

This block sits at the issue point of an in-order pipeline. Each later stage drives a result bus with fields that can be seen from the issue point: a valid bit, a write-enable, a result-ready bit, a suppress bit, a forwarding-permitted bit, the destination register number and the result data. For each source operand of the instruction waiting to issue, the controller compares the operand's register number with the destination number on every bus. No intermediate tag is looked up first. It then picks one of three sources: a forwarded value, a locally captured value, or the register-file value that was read when the instruction arrived. When the value that is needed does not yet exist, it raises a stall.

Some results must not be forwarded, for example reads of slow or performance-monitor special registers. The producing stage clears the forwarding-permitted bit for these, and consumers wait until that result reaches the final stage. A producer can also turn out to suppress its write. In that case the value to use is the one from the next older writer of the same register. That older writer may already have left the pipeline, so each operand keeps a capture register. Every cycle, the capture register loads the youngest usable matching value seen on the buses. The capture register is cleared when the instruction issues or when the pipeline is flushed.

Top module: `bypass_ctrl`

## Requirements
- R1: When no valid, write-enabled bus entry carries an operand's register number and no capture is held, the operand select is 0 (register file), the operand data equals the register-file input, and that operand raises no stall.
- R2: When the youngest live writer of an operand's register sits in stage j and is ready, not suppressed and forwardable, the select is 2+j and the operand data equals that stage's bus data. Stage 0 is the youngest stage.
- R3: When several stages match the same register, the youngest live writer decides the selection, even when older matching stages are ready.
- R4: A ready result whose forwarding-permitted bit is 0 is not forwarded from any stage except the last one, and the operand stalls on it. In the last stage (NSTAGE-1) the same result is forwarded.
- R5: When the youngest live writer of an operand's register is not yet ready, issue stalls, even if an older matching stage holds a ready value.
- R6: A writer that is ready with its suppress bit set no longer counts as a writer. The next older writer's value is then used, either forwarded or, once that writer has left, from the capture register (select 1). The stale register-file value is never used in its place.
- R7: The capture register is cleared at the clock edge on which the instruction issues (issue_valid high and stall low) or on which flush is high. In the following cycle, with no writer in flight, the select is 0 again.
- R8: Register number 0 matches and forwards like any other register. It is not hardwired to zero.
- R9: stall is low whenever issue_valid is low. An operand whose use bit is 0 never causes a stall.
- R10: Over any in-order instruction stream, the operand data at issue equals the value of the most recent non-suppressed write to that register in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is waiting to issue |
| flush | input | 1 | Pipeline flush; clears all captured operands |
| src_use | input | NOPS | Per-operand use bit |
| src_reg | input | NOPS x REG_W | Per-operand source register number |
| rf_data | input | NOPS x DATA_W | Register-file value read when the instruction arrived |
| bus_valid | input | NSTAGE | Stage holds an instruction (stage 0 youngest) |
| bus_we | input | NSTAGE | Stage instruction writes a register |
| bus_supp | input | NSTAGE | Write suppressed; meaningful only when ready |
| bus_rdy | input | NSTAGE | Result and suppress bit are known |
| bus_fwd | input | NSTAGE | Result may be forwarded before the last stage |
| bus_reg | input | NSTAGE x REG_W | Destination register number |
| bus_data | input | NSTAGE x DATA_W | Result data |
| op_sel | output | NOPS x SEL_W | Source select: 0 register file, 1 capture, 2+j stage j |
| op_data | output | NOPS x DATA_W | Selected operand value |
| stall | output | 1 | Issue must wait |

## Verification
Two functions can act in the same cycle: capturing an older writer's value, and clearing the capture register, because clearing happens on an issue or a flush while the buses may still offer a capturable match. The directed part builds this case on purpose. A capture is loaded while a suppressing younger writer is still unresolved, the select is seen to switch to the capture, and the next cycle is then either an issue or a flush with the buses quiet, after which the select must read 0 and not 1. The random part runs an in-order pipeline model with random latencies, suppression, non-forwardable results and flushes. At every issue it compares each used operand with the program-order value of its register, and on every cycle it compares stall with a model built from the requirements.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    // operand source select codes
    localparam int unsigned SEL_RF     = 0;
    localparam int unsigned SEL_CAP    = 1;
    localparam int unsigned SEL_STAGE0 = 2;

    // bits needed to encode register file, capture and every stage
    function automatic int unsigned sel_bits(int unsigned nstage);
        return $clog2(nstage + SEL_STAGE0);
    endfunction

    // bits needed to index a stage
    function automatic int unsigned idx_bits(int unsigned nstage);
        return (nstage < 2) ? 1 : $clog2(nstage);
    endfunction

    // summary of one stage as seen by one operand
    typedef struct packed {
        logic writer;   // valid, write-enabled, register number matches
        logic dropped;  // resolved as suppressed
        logic usable;   // ready, not suppressed, forwardable here
    } stage_view_t;

endpackage

// File: rtl/byp_pick.sv
module byp_pick
    import bypass_pkg::*;
#(
    parameter int unsigned NSTAGE = 3,
    parameter int unsigned REG_W  = 5,
    localparam int unsigned IDX_W = idx_bits(NSTAGE)
) (
    input  logic [REG_W-1:0]              want_reg,
    input  logic [NSTAGE-1:0]             bus_valid,
    input  logic [NSTAGE-1:0]             bus_we,
    input  logic [NSTAGE-1:0]             bus_supp,
    input  logic [NSTAGE-1:0]             bus_rdy,
    input  logic [NSTAGE-1:0]             bus_fwd,
    input  logic [NSTAGE-1:0][REG_W-1:0]  bus_reg,
    output logic                          live_hit,
    output logic [IDX_W-1:0]              live_idx,
    output logic                          live_ready,
    output logic                          cand_hit,
    output logic [IDX_W-1:0]              cand_idx
);

    stage_view_t view [NSTAGE];

    always_comb begin
        for (int j = 0; j < NSTAGE; j++) begin
            view[j].writer  = bus_valid[j] && bus_we[j] && (bus_reg[j] == want_reg);
            view[j].dropped = bus_rdy[j] && bus_supp[j];
            view[j].usable  = bus_rdy[j] && !bus_supp[j] &&
                              (bus_fwd[j] || (j == NSTAGE - 1));
        end
    end

    // scan oldest to youngest so the youngest match is left standing
    always_comb begin
        live_hit   = 1'b0;
        live_idx   = '0;
        live_ready = 1'b0;
        cand_hit   = 1'b0;
        cand_idx   = '0;
        for (int j = NSTAGE - 1; j >= 0; j--) begin
            if (view[j].writer && !view[j].dropped) begin
                live_hit   = 1'b1;
                live_idx   = IDX_W'(j);
                live_ready = view[j].usable;
            end
            if (view[j].writer && view[j].usable) begin
                cand_hit = 1'b1;
                cand_idx = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/byp_cap.sv
module byp_cap #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              held,
    output logic [DATA_W-1:0] dout
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            held <= 1'b0;
            dout <= '0;
        end else if (load) begin
            held <= 1'b1;
            dout <= din;
        end
    end

endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
    import bypass_pkg::*;
#(
    parameter int unsigned NSTAGE = 3,
    parameter int unsigned NOPS   = 3,
    parameter int unsigned REG_W  = 5,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SEL_W = sel_bits(NSTAGE),
    localparam int unsigned IDX_W = idx_bits(NSTAGE)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          issue_valid,
    input  logic                          flush,
    input  logic [NOPS-1:0]               src_use,
    input  logic [NOPS-1:0][REG_W-1:0]    src_reg,
    input  logic [NOPS-1:0][DATA_W-1:0]   rf_data,
    input  logic [NSTAGE-1:0]             bus_valid,
    input  logic [NSTAGE-1:0]             bus_we,
    input  logic [NSTAGE-1:0]             bus_supp,
    input  logic [NSTAGE-1:0]             bus_rdy,
    input  logic [NSTAGE-1:0]             bus_fwd,
    input  logic [NSTAGE-1:0][REG_W-1:0]  bus_reg,
    input  logic [NSTAGE-1:0][DATA_W-1:0] bus_data,
    output logic [NOPS-1:0][SEL_W-1:0]    op_sel,
    output logic [NOPS-1:0][DATA_W-1:0]   op_data,
    output logic                          stall
);

    logic [NOPS-1:0] op_wait;
    logic            advance;

    assign stall   = issue_valid && (|op_wait);
    assign advance = issue_valid && !stall;

    for (genvar k = 0; k < NOPS; k++) begin : g_op
        logic              live_hit, live_ready, cand_hit, cap_held;
        logic [IDX_W-1:0]  live_idx, cand_idx;
        logic [DATA_W-1:0] cap_val;

        byp_pick #(.NSTAGE(NSTAGE), .REG_W(REG_W)) u_pick (
            .want_reg  (src_reg[k]),
            .bus_valid (bus_valid),
            .bus_we    (bus_we),
            .bus_supp  (bus_supp),
            .bus_rdy   (bus_rdy),
            .bus_fwd   (bus_fwd),
            .bus_reg   (bus_reg),
            .live_hit  (live_hit),
            .live_idx  (live_idx),
            .live_ready(live_ready),
            .cand_hit  (cand_hit),
            .cand_idx  (cand_idx)
        );

        byp_cap #(.DATA_W(DATA_W)) u_cap (
            .clk  (clk),
            .rst  (rst),
            .clear(flush || advance),
            .load (src_use[k] && cand_hit),
            .din  (bus_data[cand_idx]),
            .held (cap_held),
            .dout (cap_val)
        );

        assign op_wait[k] = src_use[k] && live_hit && !live_ready;

        always_comb begin
            if (live_hit && live_ready) begin
                op_sel[k]  = SEL_W'(live_idx) + SEL_W'(SEL_STAGE0);
                op_data[k] = bus_data[live_idx];
            end else if (cap_held) begin
                op_sel[k]  = SEL_W'(SEL_CAP);
                op_data[k] = cap_val;
            end else begin
                op_sel[k]  = SEL_W'(SEL_RF);
                op_data[k] = rf_data[k];
            end
        end
    end

endmodule

// File: rtl/bypass_ctrl_chk.sv
module bypass_ctrl_chk #(
    parameter int unsigned NOPS   = 3,
    parameter int unsigned REG_W  = 5,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 3
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        issue_valid,
    input logic                        flush,
    input logic                        stall,
    input logic [NOPS-1:0]             src_use,
    input logic [NOPS-1:0][REG_W-1:0]  src_reg,
    input logic [NOPS-1:0][DATA_W-1:0] rf_data,
    input logic [NOPS-1:0][SEL_W-1:0]  op_sel,
    input logic [NOPS-1:0][DATA_W-1:0] op_data,
    input logic                        v0,
    input logic                        we0,
    input logic                        supp0,
    input logic                        rdy0,
    input logic                        fwd0,
    input logic [REG_W-1:0]            reg0,
    input logic [DATA_W-1:0]           data0
);

    assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> !stall);

    for (genvar k = 0; k < NOPS; k++) begin : g_chk
        // youngest stage usable: forwarded from stage 0
        assert_young_fwd_R2: assert property (@(posedge clk) disable iff (rst)
            (v0 && we0 && rdy0 && fwd0 && !supp0 && reg0 == src_reg[k])
            |-> (op_sel[k] == SEL_W'(2) && op_data[k] == data0));

        // youngest writer unresolved: stall when operand is used
        assert_wait_unready_R5: assert property (@(posedge clk) disable iff (rst)
            (issue_valid && src_use[k] && v0 && we0 && !rdy0 && reg0 == src_reg[k])
            |-> stall);

        // non-forwardable result in a non-final stage: stall
        assert_no_early_fwd_R4: assert property (@(posedge clk) disable iff (rst)
            (issue_valid && src_use[k] && v0 && we0 && rdy0 && !fwd0 && !supp0 &&
             reg0 == src_reg[k]) |-> stall);

        // after a flush edge no capture is offered
        assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
            $past(flush) |-> op_sel[k] != SEL_W'(1));

        // register-file select passes the register-file value
        assert_rf_path_R10: assert property (@(posedge clk) disable iff (rst)
            (op_sel[k] == SEL_W'(0)) |-> (op_data[k] == rf_data[k]));
    end

endmodule

bind bypass_ctrl bypass_ctrl_chk #(
    .NOPS(NOPS), .REG_W(REG_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .flush(flush),
    .stall(stall), .src_use(src_use), .src_reg(src_reg), .rf_data(rf_data),
    .op_sel(op_sel), .op_data(op_data),
    .v0(bus_valid[0]), .we0(bus_we[0]), .supp0(bus_supp[0]), .rdy0(bus_rdy[0]),
    .fwd0(bus_fwd[0]), .reg0(bus_reg[0]), .data0(bus_data[0])
);

// File: tb/sim_bypass_ctrl.sv
module sim_bypass_ctrl;

    localparam int NST = 3;
    localparam int NOP = 3;
    localparam int RW  = 5;
    localparam int DW  = 32;
    localparam int SW  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic                    issue_valid, flush;
    logic [NOP-1:0]          src_use;
    logic [NOP-1:0][RW-1:0]  src_reg;
    logic [NOP-1:0][DW-1:0]  rf_data;
    logic [NST-1:0]          bus_valid, bus_we, bus_supp, bus_rdy, bus_fwd;
    logic [NST-1:0][RW-1:0]  bus_reg;
    logic [NST-1:0][DW-1:0]  bus_data;
    logic [NOP-1:0][SW-1:0]  op_sel;
    logic [NOP-1:0][DW-1:0]  op_data;
    logic                    stall;

    bypass_ctrl #(.NSTAGE(NST), .NOPS(NOP), .REG_W(RW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .flush(flush),
        .src_use(src_use), .src_reg(src_reg), .rf_data(rf_data),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_supp(bus_supp),
        .bus_rdy(bus_rdy), .bus_fwd(bus_fwd), .bus_reg(bus_reg),
        .bus_data(bus_data), .op_sel(op_sel), .op_data(op_data), .stall(stall)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        bus_valid = '0; bus_we = '0; bus_supp = '0; bus_rdy = '0; bus_fwd = '0;
        bus_reg = '0; bus_data = '0;
    endtask

    task automatic put(int j, bit rdy, bit supp, bit fwd, logic [RW-1:0] r,
                       logic [DW-1:0] d);
        bus_valid[j] = 1'b1; bus_we[j] = 1'b1; bus_rdy[j] = rdy;
        bus_supp[j] = supp; bus_fwd[j] = fwd; bus_reg[j] = r; bus_data[j] = d;
    endtask

    // pipeline model for the random run
    bit              st_v [NST];
    bit              st_we [NST];
    bit              st_supp [NST];
    bit              st_fwd [NST];
    int              st_lat [NST];
    logic [RW-1:0]   st_rd [NST];
    logic [DW-1:0]   st_dat [NST];
    logic [DW-1:0]   arch [32];
    logic [DW-1:0]   expv [32];
    bit              c_we, c_supp, c_fwd;
    int              c_lat;
    logic [RW-1:0]   c_rd;
    logic [DW-1:0]   c_dat;
    logic [NOP-1:0]  c_use;
    logic [NOP-1:0][RW-1:0] c_rs;
    logic [NOP-1:0][DW-1:0] c_snap;

    task automatic new_instr();
        c_we   = ($urandom % 10) < 8;
        c_rd   = RW'($urandom % 4);
        c_supp = ($urandom % 5) == 0;
        c_fwd  = ($urandom % 10) < 7;
        c_lat  = $urandom % NST;
        c_dat  = $urandom;
        for (int k = 0; k < NOP; k++) begin
            c_use[k]  = ($urandom % 10) < 7;
            c_rs[k]   = RW'($urandom % 4);
            c_snap[k] = arch[c_rs[k]];
        end
    endtask

    // stall expected from R2, R4, R5, R6, R9
    function automatic bit model_stall();
        bit s = 0;
        for (int k = 0; k < NOP; k++) begin
            bit found = 0;
            bit ok = 0;
            for (int j = 0; j < NST; j++) begin
                bit rdy = (j >= st_lat[j]);
                if (!found && st_v[j] && st_we[j] && st_rd[j] == c_rs[k] &&
                    !(rdy && st_supp[j])) begin
                    found = 1;
                    ok = rdy && (st_fwd[j] || j == NST - 1);
                end
            end
            if (c_use[k] && found && !ok) s = 1;
        end
        return s;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_0042));
        issue_valid = 0; flush = 0; src_use = '0; src_reg = '0; rf_data = '0;
        quiet();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // reset state: no capture, no stall
        #1 chk("R9 reset stall", DW'(stall), 0);
        chk("R1 reset select", DW'(op_sel[0]), 0);

        src_use = 3'b001; src_reg[0] = 5; src_reg[1] = 20; src_reg[2] = 21;
        rf_data[0] = 32'hAAAA0000; rf_data[1] = 1; rf_data[2] = 2;
        issue_valid = 1;

        @(negedge clk); quiet();
        #1 chk("R1 select", DW'(op_sel[0]), 0);
        chk("R1 data", op_data[0], 32'hAAAA0000);
        chk("R1 stall", DW'(stall), 0);

        @(negedge clk); quiet(); put(0, 1, 0, 1, 6, 32'h66);
        #1 chk("R1 other register", DW'(op_sel[0]), 0);

        @(negedge clk); quiet(); put(1, 1, 0, 1, 5, 32'hB);
        #1 chk("R2 select", DW'(op_sel[0]), 3);
        chk("R2 data", op_data[0], 32'hB);
        chk("R2 stall", DW'(stall), 0);

        @(negedge clk); quiet(); put(0, 1, 0, 1, 5, 32'hA); put(2, 1, 0, 1, 5, 32'hC);
        #1 chk("R3 select", DW'(op_sel[0]), 2);
        chk("R3 data", op_data[0], 32'hA);

        @(negedge clk); quiet(); put(0, 1, 0, 0, 5, 32'hA);
        #1 chk("R4 stall early", DW'(stall), 1);

        @(negedge clk); quiet(); put(2, 1, 0, 0, 5, 32'hC);
        #1 chk("R4 last select", DW'(op_sel[0]), 4);
        chk("R4 last data", op_data[0], 32'hC);
        chk("R4 last stall", DW'(stall), 0);

        @(negedge clk); quiet(); put(0, 0, 0, 1, 5, 32'hA); put(1, 1, 0, 1, 5, 32'hB);
        #1 chk("R5 stall", DW'(stall), 1);

        @(negedge clk); quiet(); put(0, 1, 1, 1, 5, 32'hA); put(1, 1, 0, 1, 5, 32'hB);
        #1 chk("R6 forward older", DW'(op_sel[0]), 3);
        chk("R6 older data", op_data[0], 32'hB);
        chk("R6 no stall", DW'(stall), 0);

        // older writer leaves while younger is unresolved
        @(negedge clk); quiet(); put(1, 0, 1, 1, 5, 32'hD); put(2, 1, 0, 1, 5, 32'hC);
        #1 chk("R6 wait", DW'(stall), 1);
        @(negedge clk); quiet(); put(2, 1, 1, 1, 5, 32'hD);
        #1 chk("R6 capture select", DW'(op_sel[0]), 1);
        chk("R6 capture data", op_data[0], 32'hC);
        chk("R6 capture stall", DW'(stall), 0);

        // previous cycle issued: capture gone
        @(negedge clk); quiet();
        #1 chk("R7 issue clears", DW'(op_sel[0]), 0);
        chk("R7 issue data", op_data[0], 32'hAAAA0000);

        // capture again, then flush without issue
        @(negedge clk); quiet(); put(1, 0, 1, 1, 5, 32'hD); put(2, 1, 0, 1, 5, 32'hC);
        #1 chk("R6 wait again", DW'(stall), 1);
        @(negedge clk); quiet(); issue_valid = 0; flush = 1;
        #1 chk("R9 idle stall", DW'(stall), 0);
        chk("R6 held before flush", DW'(op_sel[0]), 1);
        @(negedge clk); flush = 0; issue_valid = 1;
        #1 chk("R7 flush clears", DW'(op_sel[0]), 0);

        @(negedge clk); quiet(); src_reg[0] = 0; put(0, 1, 0, 1, 0, 32'h1234);
        #1 chk("R8 select", DW'(op_sel[0]), 2);
        chk("R8 data", op_data[0], 32'h1234);

        @(negedge clk); quiet(); src_reg[0] = 5; src_use = 3'b010; put(0, 0, 0, 1, 5, 32'hA);
        #1 chk("R9 unused operand", DW'(stall), 0);
        @(negedge clk); issue_valid = 0; src_use = 3'b001;
        #1 chk("R9 no issue", DW'(stall), 0);

        // random in-order run
        @(negedge clk); quiet(); rst = 1; issue_valid = 0;
        @(negedge clk); rst = 0;
        for (int i = 0; i < 32; i++) begin
            arch[i] = $urandom; expv[i] = arch[i];
        end
        for (int j = 0; j < NST; j++) begin
            st_v[j] = 0; st_we[j] = 0; st_supp[j] = 0; st_fwd[j] = 0;
            st_lat[j] = 0; st_rd[j] = 0; st_dat[j] = 0;
        end
        new_instr();
        for (int cyc = 0; cyc < 6000; cyc++) begin
            bit iv, fl, es, go;
            iv = ($urandom % 10) != 0;
            fl = ($urandom % 60) == 0;
            @(negedge clk);
            issue_valid = iv; flush = fl;
            src_use = c_use; src_reg = c_rs; rf_data = c_snap;
            for (int j = 0; j < NST; j++) begin
                bus_valid[j] = st_v[j]; bus_we[j] = st_we[j];
                bus_supp[j] = st_supp[j]; bus_fwd[j] = st_fwd[j];
                bus_rdy[j] = (j >= st_lat[j]); bus_reg[j] = st_rd[j];
                bus_data[j] = st_dat[j];
            end
            #1;
            es = iv && model_stall();
            chk("R5 random stall", DW'(stall), DW'(es));
            go = iv && !es && !fl;
            if (go)
                for (int k = 0; k < NOP; k++)
                    if (c_use[k]) chk("R10 random operand", op_data[k], expv[c_rs[k]]);
            @(posedge clk);
            if (fl) begin
                for (int j = 0; j < NST; j++) st_v[j] = 0;
                for (int i = 0; i < 32; i++) expv[i] = arch[i];
                for (int k = 0; k < NOP; k++) c_snap[k] = arch[c_rs[k]];
            end else begin
                if (st_v[NST-1] && st_we[NST-1] && !st_supp[NST-1])
                    arch[st_rd[NST-1]] = st_dat[NST-1];
                for (int j = NST - 1; j > 0; j--) begin
                    st_v[j] = st_v[j-1]; st_we[j] = st_we[j-1];
                    st_supp[j] = st_supp[j-1]; st_fwd[j] = st_fwd[j-1];
                    st_lat[j] = st_lat[j-1]; st_rd[j] = st_rd[j-1];
                    st_dat[j] = st_dat[j-1];
                end
                st_v[0] = go; st_we[0] = c_we; st_supp[0] = c_supp;
                st_fwd[0] = c_fwd; st_lat[0] = c_lat; st_rd[0] = c_rd;
                st_dat[0] = c_dat;
                if (go) begin
                    if (c_we && !c_supp) expv[c_rd] = c_dat;
                    new_instr();
                end
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule